// File: doc/BRIEF.md
# Saturating Dual Event Counter Unit

This block is the performance-monitoring part of a cache controller. It holds two identical 32-bit counters. Each counter has its own configuration register, and that register chooses which cache event the counter tallies. The cache reports its events as a vector of single-cycle pulses, one bit per event kind. On each clock, every counter adds one when the event it has selected is pulsing and counting is switched on globally.

Software reaches the unit through a plain word-wide register port: write strobe, address, write data and a combinational read-data output. Through it, software can:
- program each counter's event source and its interrupt-off flag;
- reload each counter with any value, usually zero;
- start or stop all counting with one control bit.

A counter never wraps. It stops at all-ones, so a poll that comes too late loses events but never shows a misleadingly small count. A parameter selects one of two event sets. The base set has codes 1 to 9. The extended set also enables codes 10 to 15.

Top module: `evt_cnt_unit`

## Requirements
- R1: The unit has two counters, numbered 0 and 1, that behave alike and independently. In one cycle a counter either keeps its value or grows by exactly one, unless software writes it in that cycle.
- R2: A counter that holds 0xFFFFFFFF keeps that value when further selected events arrive. It does not wrap to zero.
- R3: Register offsets are as follows:
  - 0x00 holds the control register.
  - Counter n's configuration register is at 0x08 − 4·n: counter 0 at 0x08, counter 1 at 0x04.
  - Counter n's value register is at 0x10 − 4·n: counter 0 at 0x10, counter 1 at 0x0C.
- R4: A write to a value register loads the written word on the next clock edge. If an event for that counter arrives in the same cycle, the write wins and the event is not added.
- R5: Bit 0 of the control register is the global enable. While it reads 0, neither counter changes on events, whatever its configuration. The other control bits read as zero.
- R6: A configuration register has two fields:
  - Bits [5:2] hold the event-source code.
  - Bit 0 holds the interrupt-off flag.
  - All other bits read as zero.
  - Source code 0 disables the counter.
- R7: Source code k, for k from 1 to 15, counts pulses on bit k−1 of `evt_pulse`. Pulses on the other bits do not affect that counter.
- R8: With the parameter SUPERSET set to 0, source codes 0xA to 0xF count nothing. With SUPERSET set to 1 (the default), they count like the other codes.
- R9: Reset clears every register to zero. Reads of unmapped offsets return zero, and writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 8 | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| evt_pulse | input | 15 | Event pulses; bit k−1 belongs to source code k |
| rdata | output | 32 | Read data of the register at `addr` (combinational) |

## Verification
The bench presets a counter to just below all-ones and keeps pulsing its event. A design that wraps would drop the count back to a small number. It also writes a value register in the same cycle as a matching event. A design that gets this priority wrong reads back the written word plus one.

Every source code is stepped through while stray pulses arrive on the other bits. A source multiplexer that is off by one then counts the wrong event. Extended codes are driven into a second instance built with the base event set, where any count is an error.

Writes and reads on both counter addresses catch decode that swaps the descending pair. Clearing the enable mid-run catches counters that ignore the global gate.

// File: rtl/evt_pmu_pkg.sv
// Package: shared constants for the dual event counter unit.
// Assumes byte addressing with word-aligned registers.
package evt_pmu_pkg;
    localparam int CTRL_OFF    = 'h00;  // control register offset
    localparam int CFG0_OFF    = 'h08;  // counter-0 configuration offset
    localparam int VAL0_OFF    = 'h10;  // counter-0 value offset
    localparam int REG_STRIDE  = 4;     // per-counter step, descending
    localparam int SRC_LSB     = 2;     // event-source field position
    localparam int SRC_W       = 4;     // event-source field width
    localparam int IRQ_OFF_BIT = 0;     // interrupt-off flag position
    localparam int BASE_MAX    = 9;     // last code of the base event set
endpackage

// File: rtl/evt_reg_decode.sv
// Module: address decoder for the dual event counter unit.
// Produces one hit per register. Per-counter registers sit at descending
// offsets from the counter-0 address. Assumes exact full-width match.
module evt_reg_decode #(
    parameter int ADDR_W  = 8,
    parameter int NUM_CNT = 2
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic               ctrl_hit,
    output logic [NUM_CNT-1:0] cfg_hit,
    output logic [NUM_CNT-1:0] val_hit
);
    import evt_pmu_pkg::*;

    // Control register match.
    assign ctrl_hit = (addr == ADDR_W'(CTRL_OFF));

    // Per-counter matches at base minus stride times index.
    for (genvar n = 0; n < NUM_CNT; n++) begin : g_hit
        assign cfg_hit[n] = (addr == ADDR_W'(CFG0_OFF - REG_STRIDE * n));
        assign val_hit[n] = (addr == ADDR_W'(VAL0_OFF - REG_STRIDE * n));
    end

    // At most one register is selected by any address.
    always_comb begin
        assert_one_reg_R3: assert ($onehot0({ctrl_hit, cfg_hit, val_hit}));
    end
endmodule

// File: rtl/evt_counter_slice.sv
// Module: one event counter with its configuration register.
// Selects an event pulse by source code and counts it while globally enabled.
// Clamps at all-ones. A software write to the value has priority over
// counting. Assumes single-cycle event pulses, sampled on every clock edge.
module evt_counter_slice #(
    parameter int DATA_W   = 32,
    parameter int NUM_EVT  = 15,
    parameter bit SUPERSET = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               glob_en,
    input  logic               cfg_we,
    input  logic               val_we,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_EVT-1:0] evt_pulse,
    output logic [DATA_W-1:0]  cfg_rd,
    output logic [DATA_W-1:0]  cnt_q
);
    import evt_pmu_pkg::*;

    localparam int NUM_CODE = 2 ** SRC_W;

    logic [SRC_W-1:0]    src_q;
    logic                irq_off_q;
    logic [NUM_CODE-1:0] code_ok;
    logic [NUM_CODE-1:0] evt_pad;
    logic                sel_evt;
    logic                at_max;

    // Legal codes: nonzero, wired to a pulse bit, inside the chosen event set.
    for (genvar k = 0; k < NUM_CODE; k++) begin : g_code
        assign code_ok[k] = (k != 0) && (k <= NUM_EVT) && (SUPERSET || (k <= BASE_MAX));
    end

    // Code k lines up with pulse bit k-1; code 0 sees a constant zero.
    assign evt_pad = NUM_CODE'({evt_pulse, 1'b0});
    assign sel_evt = evt_pad[src_q] & code_ok[src_q];
    assign at_max  = &cnt_q;

    // Readback of the configuration fields, other bits zero.
    always_comb begin
        cfg_rd = '0;
        cfg_rd[SRC_LSB +: SRC_W] = src_q;
        cfg_rd[IRQ_OFF_BIT]      = irq_off_q;
    end

    // Configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q     <= '0;
            irq_off_q <= 1'b0;
        end else if (cfg_we) begin
            src_q     <= wdata[SRC_LSB +: SRC_W];
            irq_off_q <= wdata[IRQ_OFF_BIT];
        end
    end

    // Counter value: software load first, else saturating increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (val_we) begin
            cnt_q <= wdata;
        end else if (glob_en && sel_evt && !at_max) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The counter holds once it has reached all-ones.
    assert_hold_at_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((&cnt_q) && !val_we) |=> (&cnt_q));

    // Without a write, the counter steps by zero or one.
    assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !val_we |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));

    // A write loads exactly the written word.
    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        val_we |=> (cnt_q == $past(wdata)));

    // The global gate freezes the counter.
    assert_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_en && !val_we) |=> $stable(cnt_q));

    // Source code zero counts nothing.
    assert_src_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_rd[SRC_LSB +: SRC_W] == '0) && !val_we) |=> $stable(cnt_q));

    // The base variant ignores the extended codes.
    if (!SUPERSET) begin : g_base_chk
        assert_ext_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ((cfg_rd[SRC_LSB +: SRC_W] > SRC_W'(BASE_MAX)) && !val_we) |=> $stable(cnt_q));
    end
endmodule

// File: rtl/evt_cnt_unit.sv
// Module: top of the saturating dual event counter unit.
// Holds the global control register and the address decoder. Instantiates
// one counter slice per counter and drives a combinational read mux.
// Assumes single-cycle write strobes and reads without side effects.
module evt_cnt_unit #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    parameter int NUM_EVT  = 15,
    parameter int NUM_CNT  = 2,
    parameter bit SUPERSET = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_EVT-1:0] evt_pulse,
    output logic [DATA_W-1:0]  rdata
);
    logic               ctrl_hit;
    logic [NUM_CNT-1:0] cfg_hit;
    logic [NUM_CNT-1:0] val_hit;
    logic               glob_en_q;
    logic [DATA_W-1:0]  cfg_rd [NUM_CNT];
    logic [DATA_W-1:0]  cnt_rd [NUM_CNT];

    evt_reg_decode #(.ADDR_W(ADDR_W), .NUM_CNT(NUM_CNT)) u_dec (
        .addr     (addr),
        .ctrl_hit (ctrl_hit),
        .cfg_hit  (cfg_hit),
        .val_hit  (val_hit)
    );

    // Global enable bit of the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)                 glob_en_q <= 1'b0;
        else if (wr_en && ctrl_hit) glob_en_q <= wdata[0];
    end

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
        evt_counter_slice #(
            .DATA_W   (DATA_W),
            .NUM_EVT  (NUM_EVT),
            .SUPERSET (SUPERSET)
        ) u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .glob_en   (glob_en_q),
            .cfg_we    (wr_en && cfg_hit[n]),
            .val_we    (wr_en && val_hit[n]),
            .wdata     (wdata),
            .evt_pulse (evt_pulse),
            .cfg_rd    (cfg_rd[n]),
            .cnt_q     (cnt_rd[n])
        );
    end

    // Read mux; unmapped offsets return zero.
    always_comb begin
        rdata = '0;
        if (ctrl_hit) rdata = DATA_W'(glob_en_q);
        for (int n = 0; n < NUM_CNT; n++) begin
            if (cfg_hit[n]) rdata = cfg_rd[n];
            if (val_hit[n]) rdata = cnt_rd[n];
        end
    end
endmodule

// File: tb/tb_evt_cnt_unit.sv
// Bench: drives an extended-set instance and a base-set instance with the
// same stimulus, and compares every register against a bench model.
module tb_evt_cnt_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [14:0] evt = '0;
    logic [31:0] rdata_s, rdata_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Model state, index [variant]: 0 = extended set, 1 = base set.
    logic        m_en  [2];
    logic [31:0] m_cfg [2][2];
    logic [31:0] m_cnt [2][2];

    always #10 clk = ~clk;

    evt_cnt_unit #(.SUPERSET(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .evt_pulse(evt), .rdata(rdata_s));

    evt_cnt_unit #(.SUPERSET(1'b0)) dut_base (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .evt_pulse(evt), .rdata(rdata_b));

    // Next counter value from the requirements (R1, R2, R4, R5, R6, R7, R8).
    function automatic logic [31:0] f_next(logic [31:0] cnt, logic [31:0] cfg,
            logic en, logic [14:0] e, bit sup, bit wr_hit, logic [31:0] d);
        logic [3:0] src;
        src = cfg[5:2];
        if (wr_hit) return d;
        if (!en || src == 4'd0) return cnt;
        if (!sup && src > 4'd9) return cnt;
        if (!e[src - 4'd1]) return cnt;
        if (cnt == 32'hFFFF_FFFF) return cnt;
        return cnt + 32'd1;
    endfunction

    // Expected read data per offset (R3, R5, R6, R9).
    function automatic logic [31:0] f_read(int v, logic [7:0] a);
        case (a)
            8'h00:   return {31'd0, m_en[v]};
            8'h08:   return m_cfg[v][0];
            8'h04:   return m_cfg[v][1];
            8'h10:   return m_cnt[v][0];
            8'h0C:   return m_cnt[v][1];
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_reset();
        for (int v = 0; v < 2; v++) begin
            m_en[v] = 1'b0;
            for (int n = 0; n < 2; n++) begin
                m_cfg[v][n] = '0;
                m_cnt[v][n] = '0;
            end
        end
    endtask

    // One clock: drive at the falling edge, update the model at the rising edge.
    task automatic tick(input logic w, input logic [7:0] a, input logic [31:0] d,
                        input logic [14:0] e);
        wr_en = w; addr = a; wdata = d; evt = e;
        @(posedge clk);
        for (int v = 0; v < 2; v++) begin
            logic        en_old;
            logic [31:0] cfg_old [2];
            en_old     = m_en[v];
            cfg_old[0] = m_cfg[v][0];
            cfg_old[1] = m_cfg[v][1];
            for (int n = 0; n < 2; n++) begin
                m_cnt[v][n] = f_next(m_cnt[v][n], cfg_old[n], en_old, e, (v == 0),
                                     w && (a == 8'(16 - 4 * n)), d);
                if (w && a == 8'(8 - 4 * n)) m_cfg[v][n] = d & 32'h0000_003D;
            end
            if (w && a == 8'h00) m_en[v] = d[0];
        end
        @(negedge clk);
        wr_en = 1'b0; evt = '0;
    endtask

    task automatic chk_addr(input logic [7:0] a, input string tag);
        wr_en = 1'b0; evt = '0; addr = a;
        #1;
        checks += 2;
        if (rdata_s !== f_read(0, a)) begin
            fails++;
            $display("FAIL %s ext addr=%h actual=%h expected=%h", tag, a, rdata_s, f_read(0, a));
        end
        if (rdata_b !== f_read(1, a)) begin
            fails++;
            $display("FAIL %s base addr=%h actual=%h expected=%h", tag, a, rdata_b, f_read(1, a));
        end
    endtask

    task automatic chk_all(input string tag);
        chk_addr(8'h00, tag);
        chk_addr(8'h04, tag);
        chk_addr(8'h08, tag);
        chk_addr(8'h0C, tag);
        chk_addr(8'h10, tag);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = 32'd1234;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state, unmapped reads give zero.
        chk_all("R9 reset");
        chk_addr(8'h14, "R9 unmapped");
        chk_addr(8'h01, "R9 unmapped");
        chk_addr(8'hFC, "R9 unmapped");

        // R3, R6: field layout and descending addresses.
        tick(1, 8'h08, 32'hFFFF_FFFF, '0);
        tick(1, 8'h04, 32'h0000_0014, '0);
        tick(1, 8'h0C, 32'h1111_0000, '0);
        tick(1, 8'h10, 32'h2222_0000, '0);
        chk_all("R3 R6 layout");

        // R5: enable clear means no counting.
        tick(1, 8'h08, 32'h0000_0004, '0);
        tick(1, 8'h04, 32'h0000_0008, '0);
        repeat (4) tick(0, 8'h00, 0, 15'h7FFF);
        chk_all("R5 disabled");
        tick(1, 8'h00, 32'hFFFF_FFFF, '0);
        chk_addr(8'h00, "R5 ctrl bits");
        repeat (3) tick(0, 8'h00, 0, 15'h0003);
        chk_all("R1 R5 enabled");

        // R2: saturation at all-ones.
        tick(1, 8'h10, 32'hFFFF_FFFD, '0);
        tick(1, 8'h0C, 32'hFFFF_FFFE, '0);
        repeat (5) tick(0, 8'h00, 0, 15'h0003);
        chk_all("R2 saturate");

        // R4: a write wins over a same-cycle event.
        tick(1, 8'h10, 32'h0000_0000, 15'h0003);
        tick(1, 8'h0C, 32'h0000_0041, 15'h0003);
        chk_all("R4 write priority");

        // R7: every code maps to its own pulse bit, with stray pulses on others.
        for (int k = 1; k < 16; k++) begin
            tick(1, 8'h04, 32'(k << 2), '0);
            tick(1, 8'h0C, 32'h0, '0);
            tick(0, 8'h00, 0, 15'(1 << (k - 1)));
            tick(0, 8'h00, 0, ~15'(1 << (k - 1)));
            tick(0, 8'h00, 0, 15'(1 << (k - 1)));
            chk_addr(8'h0C, "R7 R8 code map");
        end

        // R8: extended codes on both counters.
        tick(1, 8'h08, 32'h0000_0028, '0);
        tick(1, 8'h04, 32'h0000_003C, '0);
        repeat (5) tick(0, 8'h00, 0, 15'h4200);
        chk_all("R8 extended");

        // R9: a write to an unmapped offset changes nothing.
        tick(1, 8'h14, 32'hDEAD_BEEF, '0);
        tick(1, 8'h02, 32'hDEAD_BEEF, '0);
        chk_all("R9 unmapped write");

        // R1: random mix.
        for (int i = 0; i < 3000; i++) begin
            logic [7:0]  a;
            logic [31:0] d;
            logic        w;
            w = ($urandom % 8) == 0;
            case ($urandom % 7)
                0: a = 8'h00;
                1: a = 8'h04;
                2: a = 8'h08;
                3: a = 8'h0C;
                4: a = 8'h10;
                5: a = 8'h10;
                default: a = 8'($urandom);
            endcase
            d = $urandom;
            if (a == 8'h00 && ($urandom % 4) != 0) d[0] = 1'b1;
            if ((a == 8'h0C || a == 8'h10) && ($urandom % 2)) d = 32'hFFFF_FFF0 | (d & 32'hF);
            tick(w, a, d, 15'($urandom));
            if (i % 50 == 49) chk_all("R1 R2 R4 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule